// File: doc/BRIEF.md
# Branch Hazard Fetch Stall Controller

This block steers the fetch stage of an in-order pipeline that has no branch prediction. Each cycle it decides whether the program counter moves on to the sequential address, holds its current value, or jumps to a resolved branch target. The decode stage reports the class of the instruction it holds: none, unconditional jump or call, or conditional branch. A later stage reports the resolved taken flag and the target address. Two elaboration-time parameters give the stage at whose end each class resolves. The base setting resolves jumps at stage 2 and conditional branches at stage 3, in a four-stage pipe. A deep setting resolves them at stages 5 and 10, in a fifteen-stage pipe.

A branch seen in decode during its cycle 2 leaves the sequential instruction fetched in that cycle parked in the fetch stage. No later stage takes a new instruction until the branch resolves. A redirect then squashes the parked instruction and restarts fetch at the target. A not-taken branch lets the parked instruction go on without refetching it. For a resolution stage S, a jump or a taken branch costs S−1 bubble cycles and a not-taken branch costs S−2. A saturating counter totals the bubbles, so that a testbench can read the cost at the ports.

Top module: `brhz_fetch_ctrl`

## Requirements
- R1: A synchronous active-high reset clears any pending branch. In the cycle after a reset edge, pc_sel is 3'b001 (sequential), fetch_hold and squash are 0, and bubble_cnt is 0.
- R2: pc_sel always has exactly one bit set. Bit 0 means sequential, bit 1 means hold and bit 2 means target. fetch_hold is 1 exactly when the hold bit is set.
- R3: A jump has dec_class 2'b01 and is accepted at clock edge E. pc_sel shows hold for the JUMP_RES_STAGE−2 cycles after E. The next cycle shows target with squash=1, and target_pc equals the res_target sampled at edge E+JUMP_RES_STAGE−2. The jump redirects whatever res_taken is.
- R4: A conditional branch has dec_class 2'b10. When res_taken is 1 at its resolution edge E+COND_RES_STAGE−2, it produces COND_RES_STAGE−2 hold cycles. One target cycle with squash=1 and target_pc = res_target follows, for COND_RES_STAGE−1 bubbles in all.
- R5: A conditional branch whose res_taken is 0 at its resolution edge produces COND_RES_STAGE−2 hold cycles. It then returns to sequential with no squash pulse.
- R6: res_taken and res_target are ignored at every edge except the resolution edge of a pending branch.
- R7: While a branch is pending, dec_class is ignored, including at the resolution edge. After resolution the controller goes back to sequential with no further stall.
- R8: bubble_cnt goes up by one in the same cycle as each cycle that shows fetch_hold=1 or squash=1, and it is otherwise unchanged.
- R9: bubble_cnt saturates at its all-ones value and stays there.
- R10: dec_class 2'b00 (none) and 2'b11 (reserved) start no stall and leave every output at its idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_class | input | 2 | Class of instruction in decode: 00 none, 01 jump, 10 conditional, 11 reserved |
| res_taken | input | 1 | Resolved direction of the pending conditional branch |
| res_target | input | ADDR_W | Resolved target address |
| pc_sel | output | 3 | One-hot next-PC select: bit0 sequential, bit1 hold, bit2 target |
| fetch_hold | output | 1 | Fetch stage keeps its instruction this cycle |
| squash | output | 1 | Discard the instruction parked in fetch |
| target_pc | output | ADDR_W | Redirect address, valid with the target select |
| bubble_cnt | output | CNT_W | Saturating count of bubble cycles |

## Verification
Every output is registered, so the first result of a branch accepted at edge E shows in the cycle after E. The k-th hold cycle follows edge E+k−1, and the redirect or release shows one cycle after the resolution edge E+S−2. The counter changes in that same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, so each check falls in the one cycle where the requirement places the result. The direction and target inputs carry wrong values on every edge but the resolution edge, and branch classes are driven throughout the pending window. Any early or late sampling therefore shows up as a wrong select, a wrong target or a wrong count.

// File: rtl/brhz_pkg.sv
package brhz_pkg;

  // decode-stage instruction class
  localparam logic [1:0] CLS_NONE = 2'b00;
  localparam logic [1:0] CLS_JUMP = 2'b01;
  localparam logic [1:0] CLS_COND = 2'b10;
  localparam logic [1:0] CLS_RSVD = 2'b11;

  // one-hot next-PC select
  localparam int         SEL_W    = 3;
  localparam logic [2:0] SEL_SEQ  = 3'b001;
  localparam logic [2:0] SEL_HOLD = 3'b010;
  localparam logic [2:0] SEL_TGT  = 3'b100;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             hold;
    logic             squash;
  } fe_ctl_t;

  function automatic logic is_branch(input logic [1:0] c);
    return (c == CLS_JUMP) || (c == CLS_COND);
  endfunction

endpackage

// File: rtl/brhz_wait_timer.sv
module brhz_wait_timer
  import brhz_pkg::*;
#(
  parameter int JUMP_RES_STAGE = 2,
  parameter int COND_RES_STAGE = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] dec_class,
  output logic       resolve,
  output logic       hold_req,
  output logic [1:0] res_cls
);

  // hold cycles between acceptance and resolution
  localparam int WJ   = JUMP_RES_STAGE - 2;
  localparam int WC   = COND_RES_STAGE - 2;
  localparam int WMAX = (WJ > WC) ? WJ : WC;
  localparam int RW   = (WMAX > 1) ? $clog2(WMAX) : 1;

  generate
    if (WMAX == 0) begin : g_immediate
      // both classes resolve in the acceptance cycle: no pending state
      assign resolve  = is_branch(dec_class);
      assign hold_req = 1'b0;
      assign res_cls  = dec_class;
    end else begin : g_counted
      localparam logic [RW-1:0] RJ = (WJ > 0) ? RW'(WJ - 1) : '0;
      localparam logic [RW-1:0] RC = (WC > 0) ? RW'(WC - 1) : '0;
      localparam logic          JZ = (WJ == 0);
      localparam logic          CZ = (WC == 0);

      logic          busy_q;
      logic [RW-1:0] rem_q;
      logic [1:0]    cls_q;
      logic          accept;
      logic          acc_zero;
      logic [RW-1:0] acc_rem;

      always_comb begin
        accept   = !busy_q && is_branch(dec_class);
        acc_zero = (dec_class == CLS_JUMP) ? JZ : CZ;
        acc_rem  = (dec_class == CLS_JUMP) ? RJ : RC;
      end

      assign resolve  = (accept && acc_zero) || (busy_q && (rem_q == '0));
      assign hold_req = (accept && !acc_zero) || (busy_q && (rem_q != '0));
      assign res_cls  = busy_q ? cls_q : dec_class;

      always_ff @(posedge clk) begin
        if (rst) begin
          busy_q <= 1'b0;
          rem_q  <= '0;
          cls_q  <= CLS_NONE;
        end else if (accept && !acc_zero) begin
          busy_q <= 1'b1;
          rem_q  <= acc_rem;
          cls_q  <= dec_class;
        end else if (busy_q) begin
          if (rem_q == '0) begin
            busy_q <= 1'b0;
          end else begin
            rem_q <= rem_q - RW'(1);
          end
        end
      end

      // R7: a pending branch with cycles left stays pending
      a_r7_pending_persists: assert property (@(posedge clk) disable iff (rst)
        (busy_q && (rem_q != '0)) |=> busy_q);

      // R7: the latched class cannot be replaced while pending
      a_r7_class_kept: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> (!busy_q || $stable(cls_q)));
    end
  endgenerate

endmodule

// File: rtl/brhz_redirect.sv
module brhz_redirect
  import brhz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resolve,
  input  logic              hold_req,
  input  logic [1:0]        res_cls,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic [SEL_W-1:0]  pc_sel,
  output logic              fetch_hold,
  output logic              squash,
  output logic [ADDR_W-1:0] target_pc,
  output logic              bubble
);

  logic    redirect;
  fe_ctl_t ctl_d;
  fe_ctl_t ctl_q;

  always_comb begin
    redirect = resolve && ((res_cls == CLS_JUMP) || res_taken);
    bubble   = hold_req || redirect;
    if (redirect) begin
      ctl_d = '{sel: SEL_TGT, hold: 1'b0, squash: 1'b1};
    end else if (hold_req) begin
      ctl_d = '{sel: SEL_HOLD, hold: 1'b1, squash: 1'b0};
    end else begin
      ctl_d = '{sel: SEL_SEQ, hold: 1'b0, squash: 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '{sel: SEL_SEQ, hold: 1'b0, squash: 1'b0};
      target_pc <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (redirect) begin
        target_pc <= res_target;
      end
    end
  end

  assign pc_sel     = ctl_q.sel;
  assign fetch_hold = ctl_q.hold;
  assign squash     = ctl_q.squash;

  // R2: exactly one select bit
  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(pc_sel) == 1);

  // R5: sequential select carries neither hold nor squash
  a_r5_seq_clean: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == SEL_SEQ) |-> (!squash && !fetch_hold));

endmodule

// File: rtl/brhz_sat_counter.sv
module brhz_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc && (cnt != '1)) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R9: once full, the count stays full
  a_r9_saturated_holds: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1) |=> (cnt == '1));

endmodule

// File: rtl/brhz_fetch_ctrl.sv
module brhz_fetch_ctrl
  import brhz_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int CNT_W          = 32,
  parameter int JUMP_RES_STAGE = 2,
  parameter int COND_RES_STAGE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        dec_class,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic [2:0]        pc_sel,
  output logic              fetch_hold,
  output logic              squash,
  output logic [ADDR_W-1:0] target_pc,
  output logic [CNT_W-1:0]  bubble_cnt
);

  logic       resolve;
  logic       hold_req;
  logic [1:0] res_cls;
  logic       bubble;

  brhz_wait_timer #(
    .JUMP_RES_STAGE(JUMP_RES_STAGE),
    .COND_RES_STAGE(COND_RES_STAGE)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .dec_class(dec_class),
    .resolve  (resolve),
    .hold_req (hold_req),
    .res_cls  (res_cls)
  );

  brhz_redirect #(
    .ADDR_W(ADDR_W)
  ) u_redirect (
    .clk       (clk),
    .rst       (rst),
    .resolve   (resolve),
    .hold_req  (hold_req),
    .res_cls   (res_cls),
    .res_taken (res_taken),
    .res_target(res_target),
    .pc_sel    (pc_sel),
    .fetch_hold(fetch_hold),
    .squash    (squash),
    .target_pc (target_pc),
    .bubble    (bubble)
  );

  brhz_sat_counter #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk(clk),
    .rst(rst),
    .inc(bubble),
    .cnt(bubble_cnt)
  );

  // R8: the counter steps exactly with the visible bubble cycles
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    (bubble_cnt != '1) |=> (bubble_cnt == $past(bubble_cnt) + CNT_W'(fetch_hold || squash)));

  // R2: hold flag agrees with the hold select
  a_r2_hold_matches: assert property (@(posedge clk) disable iff (rst)
    fetch_hold == (pc_sel == SEL_HOLD));

endmodule

// File: tb/brhz_fetch_ctrl_test.sv
module brhz_fetch_ctrl_test;
  import brhz_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0]  cls0 = CLS_NONE, cls1 = CLS_NONE;
  logic        tk0 = 1'b0, tk1 = 1'b0;
  logic [31:0] tg0 = '0, tg1 = '0;
  logic [2:0]  sel0, sel1;
  logic        hold0, hold1, sq0, sq1;
  logic [31:0] tpc0, tpc1;
  logic [31:0] bc0;
  logic [3:0]  bc1;

  brhz_fetch_ctrl #(.ADDR_W(32), .CNT_W(32), .JUMP_RES_STAGE(2), .COND_RES_STAGE(3)) uut (
    .clk(clk), .rst(rst), .dec_class(cls0), .res_taken(tk0), .res_target(tg0),
    .pc_sel(sel0), .fetch_hold(hold0), .squash(sq0), .target_pc(tpc0), .bubble_cnt(bc0));

  brhz_fetch_ctrl #(.ADDR_W(32), .CNT_W(4), .JUMP_RES_STAGE(5), .COND_RES_STAGE(10)) uut_deep (
    .clk(clk), .rst(rst), .dec_class(cls1), .res_taken(tk1), .res_target(tg1),
    .pc_sel(sel1), .fetch_hold(hold1), .squash(sq1), .target_pc(tpc1), .bubble_cnt(bc1));

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  longint exp_cnt [2];

  function automatic int jst(input int k); return (k == 0) ? 2 : 5; endfunction
  function automatic int cst(input int k); return (k == 0) ? 3 : 10; endfunction
  function automatic longint cmax(input int k);
    return (k == 0) ? 64'h0000_0000_FFFF_FFFF : 64'd15;
  endfunction

  function automatic logic [2:0]  g_sel(input int k);  return (k == 0) ? sel0 : sel1; endfunction
  function automatic logic        g_hold(input int k); return (k == 0) ? hold0 : hold1; endfunction
  function automatic logic        g_sq(input int k);   return (k == 0) ? sq0 : sq1; endfunction
  function automatic logic [31:0] g_tpc(input int k);  return (k == 0) ? tpc0 : tpc1; endfunction
  function automatic logic [31:0] g_cnt(input int k);  return (k == 0) ? bc0 : {28'd0, bc1}; endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input int k, input logic [1:0] c, input logic t, input logic [31:0] g);
    if (k == 0) begin cls0 = c; tk0 = t; tg0 = g; end
    else begin cls1 = c; tk1 = t; tg1 = g; end
  endtask

  task automatic bump(input int k);
    if (exp_cnt[k] < cmax(k)) exp_cnt[k]++;
  endtask

  task automatic expect_out(input int k, input logic [2:0] s, input logic h, input logic q, input string req);
    chk(req, "pc_sel", {29'd0, g_sel(k)}, {29'd0, s});
    chk(req, "fetch_hold", {31'd0, g_hold(k)}, {31'd0, h});
    chk(req, "squash", {31'd0, g_sq(k)}, {31'd0, q});
    chk("R8", "bubble_cnt", g_cnt(k), exp_cnt[k][31:0]);
  endtask

  // a branch accepted at the next edge; wrong res values except at resolution
  task automatic run_branch(input int k, input logic [1:0] c, input logic tkn, input logic [31:0] tgt);
    int    w;
    logic  redir;
    string req;
    w     = ((c == CLS_JUMP) ? jst(k) : cst(k)) - 2;
    redir = (c == CLS_JUMP) || tkn;
    req   = (c == CLS_JUMP) ? "R3 R6" : (tkn ? "R4 R6" : "R5 R6");
    @(negedge clk);
    drive(k, c, (w == 0) ? tkn : !tkn, (w == 0) ? tgt : ~tgt);
    for (int s = 1; s <= w + 1; s++) begin
      @(negedge clk);
      if (s <= w) begin
        bump(k);
        expect_out(k, SEL_HOLD, 1'b1, 1'b0, req);
        drive(k, (c == CLS_JUMP) ? CLS_COND : CLS_JUMP,
              (s == w) ? tkn : !tkn, (s == w) ? tgt : ~tgt);
      end else begin
        if (redir) bump(k);
        expect_out(k, redir ? SEL_TGT : SEL_SEQ, 1'b0, redir, req);
        if (redir) chk(req, "target_pc", g_tpc(k), tgt);
        drive(k, CLS_NONE, !tkn, ~tgt);
      end
    end
    @(negedge clk);
    expect_out(k, SEL_SEQ, 1'b0, 1'b0, "R7");
  endtask

  task automatic run_idle(input int k, input logic [1:0] c, input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      drive(k, c, i[0], 32'hA5A5_0000 + i);
      @(negedge clk);
      expect_out(k, SEL_SEQ, 1'b0, 1'b0, "R10");
    end
    drive(k, CLS_NONE, 1'b0, '0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    exp_cnt[0] = 0;
    exp_cnt[1] = 0;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) expect_out(k, SEL_SEQ, 1'b0, 1'b0, "R1");
    rst = 1'b0;

    for (int k = 0; k < 2; k++) begin
      run_idle(k, CLS_NONE, 3);
      run_idle(k, CLS_RSVD, 3);
      run_branch(k, CLS_JUMP, 1'b0, 32'h0000_1000);
      run_branch(k, CLS_COND, 1'b1, 32'h0000_2004);
      run_branch(k, CLS_COND, 1'b0, 32'h0000_3008);
      for (int i = 0; i < 3; i++) begin
        run_branch(k, CLS_JUMP, i[0], 32'h1111_0000 ^ (i << 4));
        run_branch(k, CLS_COND, 1'b1, 32'h2222_0000 + i);
        run_branch(k, CLS_COND, 1'b0, 32'h3333_0000 + i);
      end
    end

    // R9: deep instance has seen far more than 15 bubbles
    chk("R9", "bubble_cnt saturated", g_cnt(1), 32'd15);
    run_branch(1, CLS_COND, 1'b1, 32'h0000_4444);
    chk("R9", "bubble_cnt stays full", g_cnt(1), 32'd15);

    // R1: reset in the middle of a pending conditional branch
    @(negedge clk);
    drive(1, CLS_COND, 1'b0, '0);
    @(negedge clk);
    drive(1, CLS_NONE, 1'b0, '0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    exp_cnt[0] = 0;
    exp_cnt[1] = 0;
    for (int k = 0; k < 2; k++) expect_out(k, SEL_SEQ, 1'b0, 1'b0, "R1");
    rst = 1'b0;
    @(negedge clk);
    expect_out(1, SEL_SEQ, 1'b0, 1'b0, "R1");
    run_branch(1, CLS_JUMP, 1'b1, 32'h0000_5550);
    run_branch(0, CLS_COND, 1'b1, 32'h0000_6660);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule